// File: doc/BRIEF.md
# Two-Counter PWM Generator

This block drives one pulse-width-modulated output at a fixed frequency. The duty cycle is set by an N-bit input word. A prescaler counter turns the system clock into a step strobe at 2^N times the PWM frequency. An N-bit step counter advances on each strobe, so one PWM period holds 2^N steps. The output is high while the step count is below the duty word that applies to the current period.

The prescaler terminal count and its width are computed at elaboration from three parameters: the clock frequency, the PWM frequency and the resolution. The duty word is taken into an internal register only at a period boundary. A change on the input in the middle of a period therefore never produces a short or split pulse. A duty word of zero is a valid setting. It keeps the output low and gives no edges at all.

Top module: `pwm_two_stage`

## Requirements
- R1: The prescaler terminal count is DIV = CLK_HZ / (PWM_HZ * 2^RES_BITS), using integer division with a minimum of 1. Each step lasts exactly DIV clock cycles (250 with the default parameters).
- R2: The step counter is RES_BITS wide. It advances by one per step and wraps from 2^RES_BITS-1 to 0, so one PWM period is DIV * 2^RES_BITS clock cycles (4000 with the defaults).
- R3: pwm_o is high exactly while the step count is strictly less than the duty value latched for the current period. For example, duty 3 gives high on steps 0, 1 and 2 and low on steps 3 to 2^RES_BITS-1.
- R4: A latched duty of 0 keeps pwm_o low for the whole period, with no edges.
- R5: The largest duty, 2^RES_BITS-1, gives an output that is high for all steps except the last one, so it is low for exactly DIV cycles per period.
- R6: duty_i is captured only on the clock edge where the step counter wraps to 0. A change of duty_i inside a period has no effect on that period and takes effect from the next one.
- R7: An asynchronous active-low reset clears the prescaler, the step counter and the latched duty. pwm_o is low while reset is held and stays low for the whole first period after release, whatever duty_i is.
- R8: The prescaler width is max(1, ceil(log2(DIV))). When DIV is 1, a step lasts one clock cycle and the period is 2^RES_BITS cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| duty_i | input | RES_BITS | Requested duty in steps per period |
| pwm_o | output | 1 | PWM output |

## Verification
The assertions check on every cycle that the prescaler stays inside its range and counts up between strobes. They also check that the step counter holds between strobes, that the latched duty changes only at a wrap, that the output is low on the last step and for a zero duty, and that a rising output edge occurs only on step 0. Other behaviour needs whole periods to observe, so only the bench scenarios can show it. This covers the exact number of high cycles for each duty, the period length, and the deferral of a mid-period duty change. It also covers the low first period after a reset and the one-cycle-step variant.

// File: rtl/pwm_two_stage_pkg.sv
package pwm_two_stage_pkg;

  // Clock cycles per step, never below 1.
  function automatic int unsigned step_div(longint unsigned clk_hz,
                                           longint unsigned pwm_hz,
                                           int unsigned res);
    longint unsigned d;
    d = clk_hz / (pwm_hz << res);
    if (d == 0) d = 1;
    return int'(d);
  endfunction

  // max(1, ceil(log2(n)))
  function automatic int unsigned ctr_width(int unsigned n);
    if (n <= 2) return 1;
    return $clog2(n);
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned DIV = 250,
  parameter int unsigned W   = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic         tick_o,
  output logic [W-1:0] pre_o
);
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] pre_q;

  generate
    if (DIV == 1) begin : g_every
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pre_q <= '0;
        else         pre_q <= '0;
      end
      assign tick_o = 1'b1;
    end else begin : g_div
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     pre_q <= '0;
        else if (tick_o) pre_q <= '0;
        else             pre_q <= pre_q + 1'b1;
      end
      assign tick_o = (pre_q == LAST);

      // R1
      pre_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_o |=> pre_q == W'($past(pre_q) + 1'b1));
    end
  endgenerate

  assign pre_o = pre_q;

  // R1
  pre_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= LAST);

endmodule

// File: rtl/pwm_step_ctr.sv
module pwm_step_ctr #(
  parameter int unsigned RES_BITS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  output logic [RES_BITS-1:0] step_o,
  output logic                wrap_o
);
  logic [RES_BITS-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     step_q <= '0;
    else if (tick_i) step_q <= step_q + 1'b1;
  end

  assign step_o = step_q;
  assign wrap_o = tick_i && (&step_q);

  // R2
  step_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(step_q));

  // R2
  step_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> step_q == RES_BITS'($past(step_q) + 1'b1));

endmodule

// File: rtl/pwm_duty_cmp.sv
module pwm_duty_cmp #(
  parameter int unsigned RES_BITS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wrap_i,
  input  logic [RES_BITS-1:0] duty_i,
  input  logic [RES_BITS-1:0] step_i,
  output logic                pwm_o
);
  logic [RES_BITS-1:0] duty_q;

  // Capture only at period start: no partial pulses.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     duty_q <= '0;
    else if (wrap_i) duty_q <= duty_i;
  end

  assign pwm_o = (step_i < duty_q);

  // R6
  duty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(duty_q));

  // R4
  zero_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_q == '0) |-> !pwm_o);

  // R5
  last_step_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&step_i) |-> !pwm_o);

endmodule

// File: rtl/pwm_two_stage.sv
module pwm_two_stage #(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned PWM_HZ   = 25_000,
  parameter int unsigned RES_BITS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [RES_BITS-1:0] duty_i,
  output logic                pwm_o
);
  import pwm_two_stage_pkg::*;

  localparam int unsigned DIV   = step_div(CLK_HZ, PWM_HZ, RES_BITS);
  localparam int unsigned PRE_W = ctr_width(DIV);

  logic                tick;
  logic                wrap;
  logic [PRE_W-1:0]    pre;
  logic [RES_BITS-1:0] step;

  pwm_prescaler #(.DIV(DIV), .W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick),
    .pre_o  (pre)
  );

  pwm_step_ctr #(.RES_BITS(RES_BITS)) u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .step_o (step),
    .wrap_o (wrap)
  );

  pwm_duty_cmp #(.RES_BITS(RES_BITS)) u_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wrap_i (wrap),
    .duty_i (duty_i),
    .step_i (step),
    .pwm_o  (pwm_o)
  );

  // R3
  rise_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_o) |-> (step == '0) && (pre == '0));

  // R7
  reset_low_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !pwm_o);

endmodule

// File: tb/pwm_two_stage_tb_top.sv
module pwm_two_stage_tb_top;
  localparam int DIV   = 250;          // 100 MHz / (25 kHz * 16)
  localparam int STEPS = 16;
  localparam int P     = DIV * STEPS;  // 4000

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] duty_i = 4'd0;
  logic       pwm_o;
  logic       pwm_fast;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int exp_duty = 0;
  int tcyc = 0;

  always #5 clk_i = ~clk_i;

  pwm_two_stage #(.CLK_HZ(100_000_000), .PWM_HZ(25_000), .RES_BITS(4)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .duty_i(duty_i), .pwm_o(pwm_o));

  // DIV = 1 variant: 100 MHz / (6.25 MHz * 16)
  pwm_two_stage #(.CLK_HZ(100_000_000), .PWM_HZ(6_250_000), .RES_BITS(4)) dut_fast_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .duty_i(4'd5), .pwm_o(pwm_fast));

  // Reference timeline from the requirements.
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc = 0;
      exp_duty = 0;
    end else begin
      cyc = cyc + 1;
      if (cyc % P == 0) exp_duty = int'(duty_i);
    end
  end

  always @(posedge clk_i) tcyc <= tcyc + 1;

  function automatic bit exp_pwm();
    return ((cyc / DIV) % STEPS) < exp_duty;
  endfunction

  task automatic finish_sim();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic align();
    @(negedge clk_i);
    while (cyc % P != 0) @(negedge clk_i);
  endtask

  // Run n cycles from a negedge; count mismatches vs model, highs and edges.
  task automatic run(int n, output int mism, output int highs, output int edges);
    bit prev;
    mism = 0; highs = 0; edges = 0;
    prev = pwm_o;
    for (int i = 0; i < n; i++) begin
      if (pwm_o !== exp_pwm()) mism++;
      if (pwm_o) highs++;
      if (pwm_o !== prev) edges++;
      prev = pwm_o;
      @(negedge clk_i);
    end
  endtask

  task automatic t_reset();
    int m, h, e;
    duty_i = 4'd8;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check(pwm_o === 1'b0, "R7", "pwm during reset", int'(pwm_o), 0);
    rst_ni = 1'b1;
    run(P, m, h, e);
    check(h == 0, "R7", "high cycles in first period", h, 0);
    check(m == 0, "R7", "first period mismatches", m, 0);
  endtask

  task automatic t_duty(int d, string req);
    int m, h, e;
    duty_i = 4'(d);
    align();
    run(P, m, h, e);
    check(m == 0, req, $sformatf("mismatches at duty %0d", d), m, 0);
    check(h == d * DIV, req, $sformatf("high cycles at duty %0d", d), h, d * DIV);
    if (d == 0) check(e == 0, "R4", "edges at duty 0", e, 0);
    if (d == 15) check(P - h == DIV, "R5", "low cycles at max duty", P - h, DIV);
  endtask

  task automatic t_mid_change();
    int m1, h1, e1, m2, h2, e2;
    duty_i = 4'd4;
    align();
    run(P / 2 + 37, m1, h1, e1);
    duty_i = 4'd11;
    run(P / 2 - 37, m2, h2, e2);
    check(h1 + h2 == 4 * DIV, "R6", "highs in period of change", h1 + h2, 4 * DIV);
    check(m1 + m2 == 0, "R6", "mismatches in period of change", m1 + m2, 0);
    run(P, m1, h1, e1);
    check(h1 == 11 * DIV, "R6", "highs in following period", h1, 11 * DIV);
  endtask

  task automatic t_timing();
    int r1, r2, f1;
    bit prev;
    duty_i = 4'd1;
    align();
    r1 = -1; r2 = -1; f1 = -1;
    prev = pwm_o;
    for (int i = 0; i < 3 * P; i++) begin
      @(negedge clk_i);
      if (pwm_o && !prev) begin
        if (r1 < 0) r1 = tcyc; else if (r2 < 0) r2 = tcyc;
      end
      if (!pwm_o && prev && r1 >= 0 && f1 < 0) f1 = tcyc;
      prev = pwm_o;
    end
    check(r2 - r1 == P, "R2", "rise spacing", r2 - r1, P);
    check(f1 - r1 == DIV, "R1", "one-step pulse length", f1 - r1, DIV);
  endtask

  task automatic t_mid_reset();
    int m, h, e;
    duty_i = 4'd9;
    align();
    repeat (DIV) @(negedge clk_i);
    check(pwm_o === 1'b1, "R3", "high before reset", int'(pwm_o), 1);
    rst_ni = 1'b0;
    #1;
    check(pwm_o === 1'b0, "R7", "async clear of pwm", int'(pwm_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run(P, m, h, e);
    check(h == 0, "R7", "first period after mid reset", h, 0);
    run(P, m, h, e);
    check(h == 9 * DIV, "R7", "second period after mid reset", h, 9 * DIV);
  endtask

  task automatic t_fast();
    int r1, r2, f1;
    bit prev;
    r1 = -1; r2 = -1; f1 = -1;
    prev = pwm_fast;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk_i);
      if (pwm_fast && !prev) begin
        if (r1 < 0) r1 = tcyc; else if (r2 < 0) r2 = tcyc;
      end
      if (!pwm_fast && prev && r1 >= 0 && f1 < 0) f1 = tcyc;
      prev = pwm_fast;
    end
    check(r2 - r1 == 16, "R8", "DIV=1 period", r2 - r1, 16);
    check(f1 - r1 == 5, "R8", "DIV=1 high length", f1 - r1, 5);
  endtask

  initial begin
    repeat (180_000) @(posedge clk_i);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    finish_sim();
  end

  initial begin
    t_reset();
    t_fast();
    t_duty(8, "R3");
    t_duty(3, "R3");
    t_duty(0, "R4");
    t_duty(15, "R5");
    t_mid_change();
    t_timing();
    t_mid_reset();
    finish_sim();
  end

endmodule